// File: doc/BRIEF.md
# Line-Referenced Clamp Pulse Generator

This block produces the black-level clamp strobe for a video digitizer. It runs in the pixel clock domain. Its inputs are an already synchronized horizontal sync, an optional user clamp input and a few parallel configuration values. It can produce the strobe in two ways.

In internal mode the back porch is located by counting pixel clocks. Counting starts when the polarity-corrected sync leaves its active level. A programmed placement delay runs first, and a programmed number of clamp pixels follows, once per line. A trailing edge that arrives while a window is still pending or running restarts the count. Placement and duration are captured when the trailing edge is seen.

In external mode a user clamp signal is used instead. It is resynchronized through two flops and corrected for its programmed polarity before it drives the output. The mode switch acts on the output at once. The internal timer keeps running while external mode is selected.

Top module: `clampgen_top`

## Requirements
- R1: After synchronous reset, with internal mode selected, clamp_out is low and stays low until a trailing sync edge has been seen.
- R2: When hs_pol is 1, sync is active when hsync_in is high. When hs_pol is 0, sync is active when hsync_in is low. The trailing edge is a clock where the corrected level reads inactive after an active reading in the previous clock.
- R3: Let T be the clock where the first inactive sync sample is registered, with placement P and duration D (D > 0). The internal clamp is high in clocks T+1+P through T+P+D and low otherwise.
- R4: The internal clamp stays high for exactly D consecutive clocks, for any D from 1 to 255.
- R5: With P = 0, the clamp rises in the first clock after the trailing edge.
- R6: With D = 0 captured at a trailing edge, no clamp is produced for that line, and a window already in progress ends in the next clock.
- R7: A trailing edge during a pending or running window abandons that window and starts a new placement count from the new edge.
- R8: P and D are sampled at the trailing edge. Changes made later in the line do not alter the current window.
- R9: With ext_mode = 1, clamp_out follows the external path and the internal window has no effect on it. With ext_mode = 0, the external input has no effect.
- R10: With ext_pol = 1 the external clamp is active high. With ext_pol = 0 it is active low, and clamp_out is the inverse of the synchronized input.
- R11: The external input reaches clamp_out two clock edges after it is sampled, through a two-flop synchronizer.
- R12: The extreme values P = 255 and D = 255 give a window that starts 256 clocks after T and lasts 255 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Synchronized horizontal sync |
| hs_pol | input | 1 | 1: sync active high, 0: active low |
| ext_mode | input | 1 | 1: select external clamp source |
| ext_clamp_in | input | 1 | Asynchronous user clamp input |
| ext_pol | input | 1 | 1: external clamp active high, 0: active low |
| placement | input | 8 | Pixel clocks from trailing edge to clamp start |
| duration | input | 8 | Clamp width in pixel clocks, 0 disables |
| clamp_out | output | 1 | Active-high clamp strobe |

## Verification
The bench drives several cases that would go wrong in a faulty design:
- It applies both sync polarities. A design that timed from the leading edge would show its window shifted by the whole sync width.
- It uses a zero placement and a zero duration. An off-by-one counter would either delay the clamp by a pixel or let a single-pixel pulse through where none should appear.
- It retriggers during the delay and during the clamp, and it changes the configuration mid-line. A design that ignored restarts, or read the registers live, would stretch or move the window.
- It runs external mode in both polarities, checked against a two-clock delayed copy of the input. This catches a missing or extra synchronizer stage and an inverted polarity.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;

    localparam int CG_CNT_W  = 8;
    localparam int CG_SYNC_N = 2;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_WAIT = 2'd1,
        CG_HOLD = 2'd2
    } cg_state_e;

    function automatic logic cg_apply_pol(input logic lvl, input logic active_high);
        return active_high ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/clampgen_edge.sv
module clampgen_edge
    import clampgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic hs_pol,
    output logic trail
);
    logic act_now;
    logic act_prev;

    assign act_now = cg_apply_pol(hsync_in, hs_pol);

    always_ff @(posedge clk) begin
        if (rst) act_prev <= 1'b0;
        else     act_prev <= act_now;
    end

    // active level seen last clock, inactive now: end of sync
    assign trail = act_prev & ~act_now;
endmodule

// File: rtl/clampgen_timer.sv
module clampgen_timer
    import clampgen_pkg::*;
#(
    parameter int W = CG_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trail,
    input  logic [W-1:0] place,
    input  logic [W-1:0] width,
    output logic         clamp
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    cg_state_e    state;
    logic [W-1:0] cnt;
    logic [W-1:0] width_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CG_IDLE;
            cnt     <= ZERO;
            width_q <= ZERO;
            clamp   <= 1'b0;
        end else if (trail) begin
            width_q <= width;
            if (width == ZERO) begin
                state <= CG_IDLE;
                cnt   <= ZERO;
                clamp <= 1'b0;
            end else if (place == ZERO) begin
                state <= CG_HOLD;
                cnt   <= width - ONE;
                clamp <= 1'b1;
            end else begin
                state <= CG_WAIT;
                cnt   <= place - ONE;
                clamp <= 1'b0;
            end
        end else begin
            case (state)
                CG_WAIT: begin
                    if (cnt == ZERO) begin
                        state <= CG_HOLD;
                        cnt   <= width_q - ONE;
                        clamp <= 1'b1;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                CG_HOLD: begin
                    if (cnt == ZERO) begin
                        state <= CG_IDLE;
                        clamp <= 1'b0;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: begin
                    state <= CG_IDLE;
                    clamp <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clampgen_sync.sv
module clampgen_sync
    import clampgen_pkg::*;
#(
    parameter int STAGES = CG_SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clampgen_top.sv
module clampgen_top
    import clampgen_pkg::*;
#(
    parameter int W      = CG_CNT_W,
    parameter int STAGES = CG_SYNC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hsync_in,
    input  logic         hs_pol,
    input  logic         ext_mode,
    input  logic         ext_clamp_in,
    input  logic         ext_pol,
    input  logic [W-1:0] placement,
    input  logic [W-1:0] duration,
    output logic         clamp_out
);
    logic trail;
    logic int_clamp;
    logic ext_sync;

    clampgen_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .hs_pol   (hs_pol),
        .trail    (trail)
    );

    clampgen_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .trail (trail),
        .place (placement),
        .width (duration),
        .clamp (int_clamp)
    );

    clampgen_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_clamp_in),
        .q   (ext_sync)
    );

    assign clamp_out = ext_mode ? cg_apply_pol(ext_sync, ext_pol) : int_clamp;
endmodule

// File: rtl/clampgen_chk.sv
module clampgen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         hsync_in,
    input logic         hs_pol,
    input logic         ext_mode,
    input logic         ext_clamp_in,
    input logic         ext_pol,
    input logic [W-1:0] placement,
    input logic [W-1:0] duration,
    input logic         int_clamp,
    input logic         clamp_out
);
    logic       act;
    logic       act_d;
    logic       edge_seen;
    logic [1:0] age;

    assign act       = hs_pol ? hsync_in : ~hsync_in;
    assign edge_seen = act_d & ~act;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d <= 1'b0;
            age   <= 2'd0;
        end else begin
            act_d <= act;
            if (age != 2'd3) age <= age + 2'd1;
        end
    end

    // R1: first clock after reset carries no internal clamp
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd0) |-> !int_clamp);

    // R5: zero placement raises the clamp in the next clock
    a_r5_zero_place: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && placement == '0 && duration != '0) |=> int_clamp);

    // R6: zero duration gives no clamp after the edge
    a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && duration == '0) |=> !int_clamp);

    // R7: a restart with nonzero placement abandons any running window
    a_r7_restart_drops: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && placement != '0) |=> !int_clamp);

    // R11: external path is the input two edges back, polarity corrected
    a_r11_ext_latency: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && age >= 2'd2) |->
        (clamp_out == (ext_pol ? $past(ext_clamp_in, 2) : !$past(ext_clamp_in, 2))));
endmodule

bind clampgen_top clampgen_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .hsync_in     (hsync_in),
    .hs_pol       (hs_pol),
    .ext_mode     (ext_mode),
    .ext_clamp_in (ext_clamp_in),
    .ext_pol      (ext_pol),
    .placement    (placement),
    .duration     (duration),
    .int_clamp    (int_clamp),
    .clamp_out    (clamp_out)
);

// File: tb/clampgen_top_tb_top.sv
module clampgen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b1;
    logic       hs_pol = 1'b0;
    logic       ext_mode = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic       ext_pol = 1'b1;
    logic [7:0] placement = 8'h08;
    logic [7:0] duration = 8'h14;
    logic       clamp_out;

    // staged stimulus, copied into the DUT inputs just after a rising edge
    logic       s_hs = 1'b1, s_hpol = 1'b0, s_mode = 1'b0, s_ext = 1'b0, s_epol = 1'b1;
    logic [7:0] s_plc = 8'h08, s_dur = 8'h14;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int ws = 1, we = 0;
    int cyc = 0;
    bit pact = 1'b0, e1 = 1'b0, e2 = 1'b0;

    always #5 clk = ~clk;

    clampgen_top dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .hs_pol(hs_pol),
        .ext_mode(ext_mode), .ext_clamp_in(ext_clamp_in), .ext_pol(ext_pol),
        .placement(placement), .duration(duration), .clamp_out(clamp_out)
    );

    task automatic step();
        bit act, exp;
        @(posedge clk);
        #1;
        hsync_in = s_hs; hs_pol = s_hpol; ext_mode = s_mode;
        ext_clamp_in = s_ext; ext_pol = s_epol; placement = s_plc; duration = s_dur;
        act = hs_pol ? hsync_in : !hsync_in;
        if (ext_mode) exp = ext_pol ? e2 : !e2;
        else          exp = (cyc >= ws) && (cyc <= we);
        if (pact && !act) begin
            if (duration == 0) begin ws = 1; we = 0; end
            else begin ws = cyc + 1 + int'(placement); we = ws + int'(duration) - 1; end
        end
        pact = act; e2 = e1; e1 = ext_clamp_in;
        @(negedge clk);
        n_vec++;
        if (clamp_out !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d clamp_out=%b expected=%b", cur_req, cyc, clamp_out, exp);
        end
        cyc++;
    endtask

    task automatic line(int act_len, int idle_len);
        for (int i = 0; i < act_len; i++) begin s_hs = s_hpol; step(); end
        for (int i = 0; i < idle_len; i++) begin s_hs = !s_hpol; step(); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1: idle after reset, sync held inactive
        cur_req = "R1";
        for (int i = 0; i < 6; i++) step();

        // R3 R4: defaults, active-low sync
        cur_req = "R3_R4";
        line(12, 60);
        line(9, 50);

        // R2: active-high sync; trailing edge is the falling edge now
        cur_req = "R2";
        s_hpol = 1'b1; s_hs = 1'b0;
        step();
        line(15, 50);
        line(7, 45);

        // R5: zero placement
        cur_req = "R5";
        s_plc = 8'd0; s_dur = 8'd3;
        line(5, 12);
        s_dur = 8'd1;
        line(5, 8);

        // R6: zero duration, alone and killing a running window
        cur_req = "R6";
        s_dur = 8'd0; s_plc = 8'd4;
        line(5, 20);
        s_plc = 8'd0; s_dur = 8'd20;
        line(4, 6);
        s_dur = 8'd0;
        line(3, 25);

        // R7: restart during the delay and during the clamp
        cur_req = "R7";
        s_plc = 8'd8; s_dur = 8'd20;
        line(4, 5);
        s_plc = 8'd4; s_dur = 8'd5;
        line(3, 3);
        s_plc = 8'd2; s_dur = 8'd10;
        line(3, 6);
        line(2, 30);

        // R8: registers change after the edge
        cur_req = "R8";
        s_plc = 8'd6; s_dur = 8'd9;
        s_hs = s_hpol; step(); step();
        s_hs = !s_hpol; step();
        s_plc = 8'd1; s_dur = 8'd40;
        for (int i = 0; i < 30; i++) step();

        // R12: extreme placement and duration
        cur_req = "R12";
        s_plc = 8'd255; s_dur = 8'd255;
        line(3, 530);

        // R9 R10 R11: external source, active high then active low
        cur_req = "R10_R11";
        s_plc = 8'd2; s_dur = 8'd6;
        s_mode = 1'b1; s_epol = 1'b1;
        for (int i = 0; i < 40; i++) begin
            s_ext = (i % 7 == 2) || (i % 5 == 0);
            s_hs = (i % 20 < 3) ? s_hpol : !s_hpol;
            step();
        end
        s_epol = 1'b0;
        for (int i = 0; i < 30; i++) begin
            s_ext = (i % 3 == 1);
            s_hs = (i % 15 < 2) ? s_hpol : !s_hpol;
            step();
        end
        // R9: back to internal; external toggling has no effect
        cur_req = "R9";
        s_mode = 1'b0; s_epol = 1'b1;
        for (int i = 0; i < 40; i++) begin
            s_ext = i[0];
            s_hs = (i % 25 < 4) ? s_hpol : !s_hpol;
            step();
        end
        finish_run();
    end
endmodule